// File: doc/BRIEF.md
# Channel-Start Instruction Injector

This block lets a host launch a DMA channel by pushing one raw instruction through a small register window. The host first stages two 32-bit instruction words. The first word holds the first two instruction bytes and a target channel field. The second word holds the next four bytes, normally the start address of the channel program. The host then writes a launch command. The block checks that the staged opcode is the channel-start opcode. If it is, the block snapshots the six instruction bytes and the channel number and offers them on a valid/ready start port. It keeps that offer and reports busy until the channel engine takes it.

The host polls a status register before each launch and after it. The block has no start bit and does not execute channels. Its job is the staging, the check, the handshake and the busy and error reporting around the injected byte stream.

Top module: `dbg_inject_top`

## Requirements
- R1: After reset the start port is idle (`start_valid` = 0), and a status read returns 0.
- R2: Register offsets: status 0xD00, command 0xD04, word 0 at 0xD08, word 1 at 0xD0C. A launch presents `start_insn` = {word1, word0[31:24], word0[23:16]}, which puts byte 0 in bits [7:0]. It presents `start_chan` = word0[10:8]. The port goes valid on the clock edge that takes a command write of 0.
- R3: The launch is legal when the opcode byte word0[23:16] equals 0xA0 with bit 1 ignored. Bit 1 of the opcode asks for a non-secure channel and appears on `start_nonsecure`.
- R4: While `start_valid` is 1 and `start_ready` is 0, the offer and its payload hold steady. The offer drops on the edge after the one where `start_ready` is seen with it.
- R5: A command write made while busy is ignored. Word writes made while busy do not change the payload in flight.
- R6: A command write with a value other than 0 is ignored and launches nothing.
- R7: Reads of the command, word 0, word 1 and any unmapped offset return 0.
- R8: A command write of 0 with an illegal opcode launches nothing and sets a sticky error flag. The flag survives later legal launches. Writing the status offset with bit 1 set clears it.
- R9: A status read returns busy in bit 0 and the error flag in bit 1, with all other bits 0. Read data appears on the clock edge that takes the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| start_valid | output | 1 | Channel-start offer pending |
| start_ready | input | 1 | Channel engine accepts the offer |
| start_chan | output | 3 | Target channel number |
| start_insn | output | 48 | Six instruction bytes, byte 0 in the low bits |
| start_nonsecure | output | 1 | Non-secure request taken from the opcode |

## Verification
A busy flag that is set wrongly would show on two places at once: the start port and the status bit. A stuck offer leaves `start_valid` high after the acceptance edge. A missed launch leaves it low on the negative edge right after the command write. A payload path that tracks the staging registers instead of a snapshot changes `start_insn` during a hold when words are rewritten, and the next sample shows it. An error flag that is cleared or set wrongly shows in bit 1 on the very next status read.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;
  // Register offsets; the host software depends on these
  localparam logic [11:0] OFS_STATUS = 12'hD00;
  localparam logic [11:0] OFS_CMD    = 12'hD04;
  localparam logic [11:0] OFS_WORD0  = 12'hD08;
  localparam logic [11:0] OFS_WORD1  = 12'hD0C;

  // Channel-start opcode; bit 1 selects non-secure and is ignored in the check
  localparam logic [7:0] OP_CHSTART = 8'hA0;
  localparam logic [7:0] OP_CMPMASK = 8'hFD;

  // Status bit positions
  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_ERR_BIT  = 1;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_STATUS = 3'd1,
    SEL_CMD    = 3'd2,
    SEL_WORD0  = 3'd3,
    SEL_WORD1  = 3'd4
  } reg_sel_t;

  typedef enum logic [0:0] {
    LS_IDLE  = 1'b0,
    LS_OFFER = 1'b1
  } launch_st_t;
endpackage

// File: rtl/dbg_inject_regif.sv
module dbg_inject_regif
  import dbg_inject_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              err_flag,
  output logic [7:0]        stg_op0,
  output logic [7:0]        stg_op1,
  output logic [CH_W-1:0]   stg_chan,
  output logic [DATA_W-1:0] stg_w1,
  output logic              cmd_go,
  output logic              err_clr
);
  localparam int unsigned CH_LSB = 8;

  reg_sel_t          sel;
  logic              wr_en;
  logic              rd_en;
  logic [7:0]        op0_d, op1_d;
  logic [CH_W-1:0]   chan_d;
  logic [DATA_W-1:0] w1_d;
  logic [DATA_W-1:0] rdata_d;
  logic              ld_w0, ld_w1;

  // Address decode
  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else if (bus_addr == ADDR_W'(OFS_CMD)) sel = SEL_CMD;
    else if (bus_addr == ADDR_W'(OFS_WORD0)) sel = SEL_WORD0;
    else if (bus_addr == ADDR_W'(OFS_WORD1)) sel = SEL_WORD1;
  end

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;
  assign ld_w0 = wr_en & (sel == SEL_WORD0);
  assign ld_w1 = wr_en & (sel == SEL_WORD1);

  // Command strobe: only the value 0 launches
  assign cmd_go  = wr_en & (sel == SEL_CMD) & (bus_wdata == '0);
  assign err_clr = wr_en & (sel == SEL_STATUS) & bus_wdata[STAT_ERR_BIT];

  // Staging next state
  always_comb begin
    op0_d  = stg_op0;
    op1_d  = stg_op1;
    chan_d = stg_chan;
    w1_d   = stg_w1;
    if (ld_w0) begin
      op0_d  = bus_wdata[23:16];
      op1_d  = bus_wdata[31:24];
      chan_d = bus_wdata[CH_LSB +: CH_W];
    end
    if (ld_w1) begin
      w1_d = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_op0  <= '0;
      stg_op1  <= '0;
      stg_chan <= '0;
      stg_w1   <= '0;
    end else begin
      if (ld_w0) begin
        stg_op0  <= op0_d;
        stg_op1  <= op1_d;
        stg_chan <= chan_d;
      end
      if (ld_w1) begin
        stg_w1 <= w1_d;
      end
    end
  end

  // Read data: only status is readable, everything else reads zero
  always_comb begin
    rdata_d = '0;
    if (sel == SEL_STATUS) begin
      rdata_d[STAT_BUSY_BIT] = busy;
      rdata_d[STAT_ERR_BIT]  = err_flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      bus_rdata <= rdata_d;
    end
  end

  // R7: a read of any non-status offset returns zero
  a_r7_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel != SEL_STATUS) |=> (bus_rdata == '0));

  // R9: a status read reflects busy and the error flag
  a_r9_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_STATUS) |=>
      (bus_rdata[STAT_BUSY_BIT] == $past(busy)) &&
      (bus_rdata[STAT_ERR_BIT] == $past(err_flag)));
endmodule

// File: rtl/dbg_inject_opchk.sv
module dbg_inject_opchk
  import dbg_inject_pkg::*;
(
  input  logic [7:0] op_byte,
  output logic       legal,
  output logic       nonsecure
);
  assign legal     = ((op_byte & OP_CMPMASK) == OP_CHSTART);
  assign nonsecure = op_byte[1];
endmodule

// File: rtl/dbg_inject_launch.sv
module dbg_inject_launch
  import dbg_inject_pkg::*;
#(
  parameter int unsigned CH_W   = 3,
  parameter int unsigned INSN_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic              err_clr,
  input  logic              legal,
  input  logic [INSN_W-1:0] insn_in,
  input  logic [CH_W-1:0]   chan_in,
  input  logic              start_ready,
  output logic              busy,
  output logic              err_flag,
  output logic              start_valid,
  output logic [INSN_W-1:0] start_insn,
  output logic [CH_W-1:0]   start_chan
);
  launch_st_t        st_q, st_d;
  logic              accept_go;
  logic              reject_go;
  logic              err_d;
  logic              snap_en;

  assign accept_go = cmd_go & (st_q == LS_IDLE) & legal;
  assign reject_go = cmd_go & (st_q == LS_IDLE) & ~legal;
  assign snap_en   = accept_go;

  // Next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LS_IDLE:  if (accept_go) st_d = LS_OFFER;
      LS_OFFER: if (start_ready) st_d = LS_IDLE;
      default:  st_d = LS_IDLE;
    endcase
  end

  always_comb begin
    err_d = err_flag;
    if (err_clr) err_d = 1'b0;
    if (reject_go) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= LS_IDLE;
      err_flag <= 1'b0;
    end else begin
      st_q     <= st_d;
      err_flag <= err_d;
    end
  end

  // Payload snapshot, loaded only when a launch is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_insn <= '0;
      start_chan <= '0;
    end else if (snap_en) begin
      start_insn <= insn_in;
      start_chan <= chan_in;
    end
  end

  assign busy        = (st_q == LS_OFFER);
  assign start_valid = busy;

  // R4: offer and payload hold until accepted
  a_r4_offer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !start_ready) |=>
      start_valid && $stable(start_insn) && $stable(start_chan));

  // R4: offer drops after acceptance, and R5: even with a command in that cycle
  a_r4_drop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_valid);

  // R5: a command while busy never reloads the payload
  a_r5_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_go && !start_ready) |=> $stable(start_insn) && $stable(start_chan));

  // R8: illegal launch raises the error flag and starts nothing
  a_r8_reject_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy && !legal) |=> (err_flag && !start_valid));

  // R8: error is sticky unless explicitly cleared
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  // R3: any payload offered carries the channel-start opcode
  a_r3_offer_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> ((start_insn[7:0] & OP_CMPMASK) == OP_CHSTART));
endmodule

// File: rtl/dbg_inject_top.sv
module dbg_inject_top
  import dbg_inject_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NCHAN  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       start_valid,
  input  logic                       start_ready,
  output logic [$clog2(NCHAN)-1:0]   start_chan,
  output logic [DATA_W+15:0]         start_insn,
  output logic                       start_nonsecure
);
  localparam int unsigned CH_W   = $clog2(NCHAN);
  localparam int unsigned INSN_W = DATA_W + 16;

  logic [7:0]        stg_op0, stg_op1;
  logic [CH_W-1:0]   stg_chan;
  logic [DATA_W-1:0] stg_w1;
  logic              cmd_go, err_clr;
  logic              busy, err_flag;
  logic              legal, ns_unused;
  logic [INSN_W-1:0] insn_cat;

  dbg_inject_regif #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CH_W   (CH_W)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .err_flag  (err_flag),
    .stg_op0   (stg_op0),
    .stg_op1   (stg_op1),
    .stg_chan  (stg_chan),
    .stg_w1    (stg_w1),
    .cmd_go    (cmd_go),
    .err_clr   (err_clr)
  );

  dbg_inject_opchk u_opchk (
    .op_byte   (stg_op0),
    .legal     (legal),
    .nonsecure (ns_unused)
  );

  assign insn_cat = {stg_w1, stg_op1, stg_op0};

  dbg_inject_launch #(
    .CH_W   (CH_W),
    .INSN_W (INSN_W)
  ) u_launch (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_go      (cmd_go),
    .err_clr     (err_clr),
    .legal       (legal),
    .insn_in     (insn_cat),
    .chan_in     (stg_chan),
    .start_ready (start_ready),
    .busy        (busy),
    .err_flag    (err_flag),
    .start_valid (start_valid),
    .start_insn  (start_insn),
    .start_chan  (start_chan)
  );

  // Non-secure request rides in bit 1 of the offered opcode byte
  assign start_nonsecure = start_insn[1];

  // R3: the staged opcode's security bit matches what is later offered
  a_r3_ns_tracks_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy && legal) |=> (start_nonsecure == $past(ns_unused)));
endmodule

// File: tb/tb_dbg_inject_top.sv
module tb_dbg_inject_top;
  localparam logic [11:0] A_STAT = 12'hD00;
  localparam logic [11:0] A_CMD  = 12'hD04;
  localparam logic [11:0] A_W0   = 12'hD08;
  localparam logic [11:0] A_W1   = 12'hD0C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        start_valid, start_ready;
  logic [2:0]  start_chan;
  logic [47:0] start_insn;
  logic        start_nonsecure;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  bit exp_err  = 1'b0;

  always #2.5 clk = ~clk;

  dbg_inject_top dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_chan(start_chan), .start_insn(start_insn),
    .start_nonsecure(start_nonsecure)
  );

  function automatic logic [47:0] f_insn(logic [31:0] w0, logic [31:0] w1);
    return {w1, w0[31:24], w0[23:16]};
  endfunction

  function automatic bit f_legal(logic [31:0] w0);
    return (w0[23:16] & 8'hFD) == 8'hA0;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic bwrite(logic [11:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic stat_chk(logic busy_e, string req);
    logic [31:0] d;
    bread(A_STAT, d);
    chk(d == {30'b0, exp_err, busy_e}, req, d, {30'b0, exp_err, busy_e});
  endtask

  // Full launch with random hold; optional busy-time disturbance (R5)
  task automatic launch(logic [31:0] w0, logic [31:0] w1, int hold, bit disturb);
    logic [47:0] e;
    bwrite(A_W0, w0);
    bwrite(A_W1, w1);
    bwrite(A_CMD, 32'h0);
    if (!f_legal(w0)) begin
      exp_err = 1'b1;
      chk(start_valid == 1'b0, "R8 no launch on bad opcode", start_valid, 0);
      stat_chk(1'b0, "R8 error flag");
      return;
    end
    e = f_insn(w0, w1);
    chk(start_valid == 1'b1, "R2 valid after cmd", start_valid, 1);
    chk(start_insn == e, "R2 byte order", start_insn, e);
    chk(start_chan == w0[10:8], "R2 channel field", start_chan, w0[10:8]);
    chk(start_nonsecure == w0[17], "R3 nonsecure bit", start_nonsecure, w0[17]);
    stat_chk(1'b1, "R9 busy in status");
    for (int i = 0; i < hold; i++) @(negedge clk);
    if (disturb) begin
      bwrite(A_W0, 32'h00A2_0500);
      bwrite(A_W1, ~w1);
      bwrite(A_CMD, 32'h0);
    end
    chk(start_valid == 1'b1, "R4 offer held", start_valid, 1);
    chk(start_insn == e, "R5 payload unchanged while busy", start_insn, e);
    start_ready = 1'b1;
    @(negedge clk);
    start_ready = 1'b0;
    chk(start_valid == 1'b0, "R4 drop after accept", start_valid, 0);
    if (disturb) begin
      @(negedge clk);
      chk(start_valid == 1'b0, "R5 no second launch", start_valid, 0);
    end
    stat_chk(1'b0, "R9 idle in status");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w0, w1;
    logic [7:0]  op;
    logic [2:0]  ch;
    int          seed_junk;
    seed_junk = $urandom(32'h5EED_0042);
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; start_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(start_valid == 1'b0, "R1 idle after reset", start_valid, 0);
    stat_chk(1'b0, "R1 status after reset");

    // R7 write-only and unmapped reads
    bwrite(A_W0, 32'hFFFF_FFFF);
    bwrite(A_W1, 32'hFFFF_FFFF);
    bread(A_CMD, d);  chk(d == 0, "R7 cmd reads 0", d, 0);
    bread(A_W0, d);   chk(d == 0, "R7 word0 reads 0", d, 0);
    bread(A_W1, d);   chk(d == 0, "R7 word1 reads 0", d, 0);
    bread(12'h123, d); chk(d == 0, "R7 unmapped reads 0", d, 0);

    // R6 nonzero command ignored (staged illegal opcode would set error)
    bwrite(A_CMD, 32'h1);
    @(negedge clk);
    chk(start_valid == 1'b0, "R6 nonzero cmd ignored", start_valid, 0);
    stat_chk(1'b0, "R6 no error from nonzero cmd");

    // Directed: secure and non-secure, boundary channels, zero hold
    launch(32'h00A0_0000, 32'h1000_0000, 0, 1'b0);
    launch(32'h07A2_0700, 32'hFFFF_FFFC, 3, 1'b0);
    // R5 disturbance while busy
    launch(32'h03A0_0300, 32'h2000_0040, 1, 1'b1);

    // R8 illegal opcode, then sticky across a legal launch, then clear
    launch(32'h0004_0200, 32'h0, 0, 1'b0);
    launch(32'h02A2_0200, 32'h3000_0000, 2, 1'b0);
    stat_chk(1'b0, "R8 error sticky");
    bwrite(A_STAT, 32'h1);
    stat_chk(1'b0, "R8 bit0 write does not clear");
    bwrite(A_STAT, 32'h2);
    exp_err = 1'b0;
    stat_chk(1'b0, "R8 error cleared");

    // Random mix
    for (int n = 0; n < 60; n++) begin
      ch = 3'($urandom_range(0, 7));
      op = ($urandom_range(0, 4) == 0) ? 8'($urandom) : (8'hA0 | {6'b0, 1'($urandom), 1'b0});
      w0 = {5'b0, ch, op, 5'($urandom), ch, 8'($urandom)};
      w1 = $urandom;
      launch(w0, w1, $urandom_range(0, 5), 1'($urandom_range(0, 3) == 0));
      if (exp_err && $urandom_range(0, 1) == 1) begin
        bwrite(A_STAT, 32'h2);
        exp_err = 1'b0;
        stat_chk(1'b0, "R8 random clear");
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule